// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block counts system clock cycles and, when a programmable interval elapses, raises a sticky timeout flag and, if enabled, an interrupt. The expiry opens a second stage of exactly 512 cycles. If software does not restart the count within that stage and the reset enable is set, the block emits a one-cycle system reset pulse and latches a reset-cause flag. Software then clears that flag when it chooses.

The interval is a power of two. It is selected by a 2-bit range field, a 2-bit clock-divide field and a power-management mode bit, so that the timeout follows the effective CPU clock. In normal mode the exponent is `EXP_BASE + 3*range + divide`. In power-management mode the divide field is ignored and the exponent is `EXP_BASE + 8 + 3*range`. `EXP_BASE` defaults to 12, which gives 2^12 to 2^29 cycles. A smaller value shortens every interval but leaves the 512-cycle reset stage unchanged. Any change of the selection inputs restarts the count, so a new interval never expires early.

The controller is a three-state machine:
- `WS_COUNT` measures the interval. On terminal count it moves to `WS_WINDOW`.
- `WS_WINDOW` measures the 512-cycle reset stage. At its end it moves to `WS_FIRE` when the reset enable is set, and otherwise back to `WS_COUNT`.
- `WS_FIRE` lasts one cycle and returns to `WS_COUNT`.

A restart (a restart strobe or a change of the selection inputs) forces `WS_COUNT` with a cleared count from any state.

Top module: `twostage_wdt`

## Requirements
- R1: After reset, `irq_flag`, `irq`, `sys_rst` and `rst_cause` are 0 and counting starts from zero in `WS_COUNT`.
- R2: With `pm_mode`=0, `irq_flag` rises exactly 2^(EXP_BASE+3*wd_sel+cd_sel) clock edges after the edge that samples a restart.
- R3: With `pm_mode`=1, `irq_flag` rises exactly 2^(EXP_BASE+8+3*wd_sel) edges after a restart, whatever the value of `cd_sel`.
- R4: `irq_flag` is set at expiry regardless of `irq_en`. `irq` is 1 exactly when `irq_flag` is 1 and `irq_en` is 1.
- R5: If no restart occurs and `rst_en`=1, `sys_rst` is high for exactly one cycle, starting 512 edges after the edge that set `irq_flag`. The interval count then restarts from zero.
- R6: A `kick` sampled in any state restarts the count and abandons a pending reset stage. A `kick` sampled on the same edge as an expiry wins, and no flag or pulse results.
- R7: If `rst_en`=0 when the reset stage ends, no `sys_rst` pulse is produced, `rst_cause` is not set, and the interval count restarts.
- R8: `rst_cause` is set on the edge that starts the `sys_rst` pulse and holds until `cause_clr` is sampled. `irq_flag` holds until `irq_clr` is sampled. In both flags a set on the same edge as a clear wins.
- R9: A change of `wd_sel`, `cd_sel` or `pm_mode` restarts the count on the edge that first samples the new value.
- R10: The parameter `EXP_BASE` shifts every interval exponent by the same amount, while the reset stage stays at 512 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick | input | 1 | Restart strobe, one cycle |
| wd_sel | input | 2 | Interval range field |
| cd_sel | input | 2 | Current clock-divide setting |
| pm_mode | input | 1 | Power-management mode; when set, `cd_sel` is ignored |
| irq_en | input | 1 | Interrupt enable |
| rst_en | input | 1 | Reset enable for the second stage |
| irq_clr | input | 1 | Clears `irq_flag` |
| cause_clr | input | 1 | Clears `rst_cause` |
| irq_flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request |
| sys_rst | output | 1 | One-cycle system reset pulse |
| rst_cause | output | 1 | Sticky flag: a watchdog reset occurred |

## Verification
The risky coincidences are these:
- A restart strobe arrives on the very edge at which the interval expires. The bench drives `kick` so that it is sampled on exactly the terminal edge, then checks that `irq_flag` stays low and that the next expiry comes one full interval later.
- A `cause_clr` is sampled on the edge that starts the reset pulse. The bench checks that `rst_cause` stays set.

A behavioural reference model built on integers runs beside the design and is compared with every output on every clock. A change of selection inputs in mid-interval is timed against the restarted interval.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int WIN_CYCLES = 512;

    typedef enum logic [1:0] {
        WS_COUNT  = 2'd0,
        WS_WINDOW = 2'd1,
        WS_FIRE   = 2'd2
    } wdt_state_e;

    typedef struct packed {
        logic       pm;
        logic [1:0] wd;
        logic [1:0] cd;
    } wdt_cfg_t;
endpackage

// File: rtl/wdt_period.sv
module wdt_period
    import wdt_pkg::*;
#(
    parameter int EXP_BASE = 12,
    parameter int CNT_W    = 29
) (
    input  wdt_cfg_t           cfg,
    output logic [CNT_W-1:0]   term
);
    localparam logic [5:0] BASE6 = 6'(EXP_BASE);

    logic [3:0] wd_x3;
    logic [5:0] expo;

    always_comb begin
        wd_x3 = {1'b0, cfg.wd, 1'b0} + {2'b00, cfg.wd};
        if (cfg.pm) begin
            expo = BASE6 + 6'd8 + {2'b00, wd_x3};
        end else begin
            expo = BASE6 + {2'b00, wd_x3} + {4'b0000, cfg.cd};
        end
        term = CNT_W'(({{CNT_W{1'b0}}, 1'b1} << expo) - 1'b1);
    end
endmodule

// File: rtl/wdt_flag.sv
module wdt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
    import wdt_pkg::*;
#(
    parameter int EXP_BASE = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kick,
    input  logic [1:0] wd_sel,
    input  logic [1:0] cd_sel,
    input  logic       pm_mode,
    input  logic       irq_en,
    input  logic       rst_en,
    input  logic       irq_clr,
    input  logic       cause_clr,
    output logic       irq_flag,
    output logic       irq,
    output logic       sys_rst,
    output logic       rst_cause
);
    localparam int EXP_MAX = EXP_BASE + 17;
    localparam int CNT_W   = (EXP_MAX > 9) ? EXP_MAX : 9;
    localparam logic [CNT_W-1:0] WIN_TERM = CNT_W'(WIN_CYCLES - 1);

    wdt_state_e       state, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt, term;
    wdt_cfg_t         cfg_now, cfg_q;
    logic             restart, set_irq, set_cause;

    assign cfg_now = '{pm: pm_mode, wd: wd_sel, cd: cd_sel};
    assign restart = kick | (cfg_now != cfg_q);

    wdt_period #(.EXP_BASE(EXP_BASE), .CNT_W(CNT_W)) u_period (
        .cfg  (cfg_now),
        .term (term)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WS_COUNT;
            cnt   <= '0;
            cfg_q <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            cfg_q <= cfg_now;
        end
    end

    // next state
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt + 1'b1;
        if (restart) begin
            nxt     = WS_COUNT;
            cnt_nxt = '0;
        end else begin
            unique case (state)
                WS_COUNT: begin
                    if (cnt == term) begin
                        nxt     = WS_WINDOW;
                        cnt_nxt = '0;
                    end
                end
                WS_WINDOW: begin
                    if (cnt == WIN_TERM) begin
                        nxt     = rst_en ? WS_FIRE : WS_COUNT;
                        cnt_nxt = '0;
                    end
                end
                WS_FIRE: begin
                    nxt     = WS_COUNT;
                    cnt_nxt = '0;
                end
                default: begin
                    nxt     = WS_COUNT;
                    cnt_nxt = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        set_irq   = (state == WS_COUNT) && (nxt == WS_WINDOW);
        set_cause = (state == WS_WINDOW) && (nxt == WS_FIRE);
        sys_rst   = (state == WS_FIRE);
        irq       = irq_flag & irq_en;
    end

    wdt_flag u_irq_flag (
        .clk(clk), .rst_n(rst_n), .set(set_irq), .clr(irq_clr), .q(irq_flag)
    );

    wdt_flag u_cause_flag (
        .clk(clk), .rst_n(rst_n), .set(set_cause), .clr(cause_clr), .q(rst_cause)
    );
endmodule

// File: rtl/twostage_wdt_chk.sv
module twostage_wdt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       kick,
    input logic [1:0] wd_sel,
    input logic [1:0] cd_sel,
    input logic       pm_mode,
    input logic       rst_en,
    input logic       irq_flag,
    input logic       sys_rst,
    input logic       rst_cause
);
    assert_kick_blocks_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !$rose(irq_flag));

    assert_kick_blocks_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !sys_rst);

    assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !sys_rst);

    assert_rst_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> $past(rst_en));

    assert_cause_with_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_cause) |-> sys_rst);

    assert_cfg_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({pm_mode, wd_sel, cd_sel}) |=> !$rose(irq_flag));
endmodule

bind twostage_wdt twostage_wdt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .kick(kick), .wd_sel(wd_sel), .cd_sel(cd_sel),
    .pm_mode(pm_mode), .rst_en(rst_en), .irq_flag(irq_flag),
    .sys_rst(sys_rst), .rst_cause(rst_cause)
);

// File: tb/test_twostage_wdt.sv
module test_twostage_wdt;
    localparam int BASE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kick = 1'b0, pm_mode = 1'b0, irq_en = 1'b0, rst_en = 1'b0;
    logic irq_clr = 1'b0, cause_clr = 1'b0;
    logic [1:0] wd_sel = 2'd0, cd_sel = 2'd0;
    logic irq_flag, irq, sys_rst, rst_cause;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    twostage_wdt #(.EXP_BASE(BASE)) i_twostage_wdt (
        .clk(clk), .rst_n(rst_n), .kick(kick), .wd_sel(wd_sel), .cd_sel(cd_sel),
        .pm_mode(pm_mode), .irq_en(irq_en), .rst_en(rst_en), .irq_clr(irq_clr),
        .cause_clr(cause_clr), .irq_flag(irq_flag), .irq(irq),
        .sys_rst(sys_rst), .rst_cause(rst_cause)
    );

    // behavioural reference model
    int   m_cnt = 0;
    int   m_state = 0;
    bit   m_flag = 1'b0, m_cause = 1'b0;
    logic [4:0] m_cfg = 5'd0;

    function automatic int period(logic pm, logic [1:0] wd, logic [1:0] cd);
        return 1 << (pm ? BASE + 8 + 3 * int'(wd) : BASE + 3 * int'(wd) + int'(cd));
    endfunction

    always @(posedge clk) begin
        bit restart, s_irq, s_cause;
        if (!rst_n) begin
            m_cnt = 0; m_state = 0; m_flag = 0; m_cause = 0; m_cfg = 5'd0;
        end else begin
            restart = kick || ({pm_mode, wd_sel, cd_sel} != m_cfg);
            m_cfg   = {pm_mode, wd_sel, cd_sel};
            s_irq   = 0;
            s_cause = 0;
            if (restart) begin
                m_state = 0; m_cnt = 0;
            end else if (m_state == 0) begin
                if (m_cnt == period(pm_mode, wd_sel, cd_sel) - 1) begin
                    m_state = 1; m_cnt = 0; s_irq = 1;
                end else m_cnt++;
            end else if (m_state == 1) begin
                if (m_cnt == 511) begin
                    m_state = rst_en ? 2 : 0; m_cnt = 0; s_cause = rst_en;
                end else m_cnt++;
            end else begin
                m_state = 0; m_cnt = 0;
            end
            m_flag  = s_irq   ? 1'b1 : (irq_clr   ? 1'b0 : m_flag);
            m_cause = s_cause ? 1'b1 : (cause_clr ? 1'b0 : m_cause);
        end
    end

    task automatic chk(string req, logic act, logic exp, string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0b exp=%0b", req, what, act, exp);
        end
    endtask

    task automatic chk_int(string req, int act, int exp, string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // compare against the model every cycle
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R2", irq_flag, m_flag, "irq_flag vs model");
            chk("R4", irq, m_flag & irq_en, "irq vs model");
            chk("R5", sys_rst, m_state == 2, "sys_rst vs model");
            chk("R8", rst_cause, m_cause, "rst_cause vs model");
        end
    end

    task automatic restart_clear();
        @(negedge clk); kick = 1; irq_clr = 1; cause_clr = 1;
        @(negedge clk); kick = 0; irq_clr = 0; cause_clr = 0;
    endtask

    task automatic wait_flag(output int n, input int limit);
        n = 0;
        while (!irq_flag && n < limit) begin @(negedge clk); n++; end
    endtask

    task automatic wait_rst(output int n, input int limit);
        n = 0;
        while (!sys_rst && n < limit) begin @(negedge clk); n++; end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog act=timeout exp=completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1", irq_flag, 1'b0, "irq_flag in reset");
        chk("R1", irq, 1'b0, "irq in reset");
        chk("R1", sys_rst, 1'b0, "sys_rst in reset");
        chk("R1", rst_cause, 1'b0, "rst_cause in reset");
        rst_n = 1;

        // R2 R10: shortest interval, then reset stage
        irq_en = 1; rst_en = 1;
        restart_clear();
        wait_flag(n, 100);
        chk_int("R2 R10", n, period(0, 0, 0), "interval wd0 cd0");
        chk("R4", irq, 1'b1, "irq with enable");
        wait_rst(n, 1000);
        chk_int("R5", n, 512, "reset stage length");
        chk("R8", rst_cause, 1'b1, "cause with pulse");
        @(negedge clk);
        chk("R5", sys_rst, 1'b0, "pulse is one cycle");

        // R2 with divide
        wd_sel = 2'd1; cd_sel = 2'd2;
        restart_clear();
        wait_flag(n, 1000);
        chk_int("R2", n, period(0, 1, 2), "interval wd1 cd2");

        // R3 power-management mode ignores divide
        pm_mode = 1; wd_sel = 2'd0; cd_sel = 2'd3;
        restart_clear();
        wait_flag(n, 5000);
        chk_int("R3", n, 1 << (BASE + 8), "pm interval cd3");
        cd_sel = 2'd0;
        restart_clear();
        wait_flag(n, 5000);
        chk_int("R3", n, 1 << (BASE + 8), "pm interval cd0");

        // R4 interrupt disabled
        pm_mode = 0; wd_sel = 2'd0; irq_en = 0;
        restart_clear();
        wait_flag(n, 100);
        chk_int("R4", n, 4, "flag without enable");
        chk("R4", irq, 1'b0, "irq masked");
        irq_en = 1;

        // R6 kick inside the reset stage
        repeat (300) @(negedge clk);
        @(negedge clk); kick = 1; @(negedge clk); kick = 0;
        n = 0;
        repeat (500) begin @(negedge clk); if (sys_rst) n++; end
        chk_int("R6", n, 0, "no pulse after kick in stage");

        // R6 kick on the expiry edge
        restart_clear();
        repeat (3) @(negedge clk);
        kick = 1; @(negedge clk); kick = 0;
        chk("R6", irq_flag, 1'b0, "kick wins over expiry");
        wait_flag(n, 100);
        chk_int("R6", n, 4, "interval after coincident kick");

        // R7 reset disabled
        rst_en = 0;
        restart_clear();
        wait_flag(n, 100);
        wait_rst(n, 600);
        chk_int("R7", n, 600, "no pulse when disabled");
        chk("R7", rst_cause, 1'b0, "no cause when disabled");

        // R8 set beats clear
        rst_en = 1;
        restart_clear();
        wait_flag(n, 100);
        repeat (511) @(negedge clk);
        cause_clr = 1; @(negedge clk); cause_clr = 0;
        chk("R8", sys_rst, 1'b1, "pulse on coincident clear");
        chk("R8", rst_cause, 1'b1, "set wins over clear");
        cause_clr = 1; irq_clr = 1; @(negedge clk); cause_clr = 0; irq_clr = 0;
        chk("R8", rst_cause, 1'b0, "cause cleared");
        chk("R8", irq_flag, 1'b0, "flag cleared");

        // R9 selection change restarts the count
        wd_sel = 2'd1; cd_sel = 2'd0;
        restart_clear();
        repeat (20) @(negedge clk);
        cd_sel = 2'd1;
        wait_flag(n, 500);
        chk_int("R9", n, period(0, 1, 1) + 1, "restart on cfg change");

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule